// File: doc/BRIEF.md
# Bit-Serial Transposed Compute Array

This block is a small storage array that doubles as a vector arithmetic engine. A vector element is stored vertically: each element owns one bit line (column) and each of its bit positions sits on its own word line (row), least significant bit at the lowest row of its group. Every column carries a peripheral with a carry latch, a tag (predicate) latch and a four-way write-back selector. A dual-row read gives, per column, the AND and the NOR of the two addressed bits; the XOR and the full-adder outputs are built from those two results. Every column then works in parallel, one bit slice per cycle.

A client issues an operation by pulsing `op_start` with an operation code, the base rows of the two operands, the base row of the result and an element width. Addition takes n+1 cycles and writes an (n+1)-bit sum. Multiplication clears the 2n product rows. For each multiplier bit it then loads that bit into the tag latch and adds the shifted multiplicand into the product rows, but only in tagged columns. The run takes n*n+5n-2 cycles. Between operations the same rows are reached through an ordinary row read/write port, which is how operands are placed and results collected.

Top module: `bitserial_cim`

## Requirements
- R1: After reset `busy` and `done` are 0, and every row of the array reads as all zeros.
- R2: While `busy` is 0, an asserted `acc_req` is granted in the same cycle (`acc_gnt`=1). A write (`acc_we`=1) stores `acc_wdata` into row `acc_row`. A read returns that row on `acc_rdata` in the cycle after the grant.
- R3: With `op_code`=2'b01 (add) and width n, each column c gets the n-bit A element from rows `a_base`..`a_base`+n-1 and the B element from rows `b_base`..`b_base`+n-1, bit k in row base+k. It receives their sum in rows `d_base`..`d_base`+n, with the final carry in row `d_base`+n.
- R4: An accepted add keeps `busy` high for exactly n+1 cycles, starting in the cycle after `op_start` is sampled. `done` is then high for exactly one cycle, with `busy` low.
- R5: With `op_code`=2'b10 (multiply) and width n, each column receives the unsigned 2n-bit product of its A (multiplicand) and B (multiplier) elements in rows `d_base`..`d_base`+2n-1, least significant bit first. Columns whose multiplier bit is 0 do not write during that bit's partial-product add.
- R6: An accepted multiply keeps `busy` high for exactly n*n+5n-2 cycles, after which `done` pulses for one cycle.
- R7: While `busy` is 1, `acc_gnt` stays 0 and a requested write leaves the array unchanged. A requester must hold its request until it is granted.
- R8: `op_start` is ignored while `busy` is 1, and also when `op_code` is 2'b00 or 2'b11, or when the width is 0 or above `MAXW`. An ignored start raises neither `busy` nor `done`.
- R9: The carry latches are cleared when an operation is accepted, so a carry left over from an earlier operation never enters the next result.
- R10: An operation writes no row outside its result window (n+1 rows for add, 2n rows for multiply), and its operand rows keep their contents when they do not overlap that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Request to start an operation |
| op_code | input | 2 | 2'b01 add, 2'b10 multiply, others illegal |
| a_base | input | $clog2(ROWS) | First row of operand A (multiplicand) |
| b_base | input | $clog2(ROWS) | First row of operand B (multiplier) |
| d_base | input | $clog2(ROWS) | First row of the result |
| op_width | input | $clog2(MAXW+1) | Element width n in bits, 1..MAXW |
| busy | output | 1 | Operation in progress; row port stalled |
| done | output | 1 | One-cycle pulse after an operation completes |
| acc_req | input | 1 | Row port request |
| acc_we | input | 1 | Row port write (1) or read (0) |
| acc_row | input | $clog2(ROWS) | Row port address |
| acc_wdata | input | COLS | Row port write data, one bit per column |
| acc_gnt | output | 1 | Row port request granted this cycle |
| acc_rdata | output | COLS | Row port read data, valid the cycle after a granted read |

## Verification
A carry latch that is stale or updated on the wrong cycle first shows in the top rows of a sum or a product, in the very operation where the fault occurs. A tag latch that fails to block a write corrupts the product of any column whose multiplier holds a zero bit. Random multipliers expose this in the first multiply. Any slip in the phase sequence changes the number of `busy` cycles before `done`, so it is visible at the ports as soon as the operation ends. A leak through the stalled row port is only seen when the touched row is read back after `done`.

// File: rtl/cim_pkg.sv
package cim_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_ADD  = 2'b01,
      OP_MUL  = 2'b10,
      OP_RSV  = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      WB_SUM   = 2'b00,
      WB_CARRY = 2'b01,
      WB_DIN   = 2'b10,
      WB_TAG   = 2'b11
   } wb_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ZERO = 3'd1,
      PH_TAG  = 3'd2,
      PH_CLR  = 3'd3,
      PH_ADD  = 3'd4,
      PH_STC  = 3'd5
   } phase_e;

endpackage

// File: rtl/bsc_col.sv
module bsc_col
   import cim_pkg::*;
#(
   parameter bit SENSE_XOR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_bit,
   input  logic b_bit,
   input  logic din_bit,
   input  wb_e  wb_sel,
   input  logic pred,
   input  logic tag_load,
   input  logic carry_clr,
   input  logic carry_upd,
   output logic wr_bit,
   output logic wr_mask,
   output logic carry_o
);

   logic and_s, nor_s, xor_s;
   logic sum_s, cout_s;
   logic carry_q, tag_q;

   assign and_s = a_bit & b_bit;
   assign nor_s = ~(a_bit | b_bit);

   generate
      if (SENSE_XOR) begin : g_xor_sense
         assign xor_s = ~(and_s | nor_s);
      end else begin : g_xor_direct
         assign xor_s = a_bit ^ b_bit;
      end
   endgenerate

   assign sum_s  = xor_s ^ carry_q;
   assign cout_s = and_s | (xor_s & carry_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
         tag_q   <= 1'b0;
      end else begin
         if (carry_clr)
            carry_q <= 1'b0;
         else if (carry_upd)
            carry_q <= cout_s;
         if (tag_load)
            tag_q <= and_s;
      end
   end

   always_comb begin
      unique case (wb_sel)
         WB_SUM:   wr_bit = sum_s;
         WB_CARRY: wr_bit = carry_q;
         WB_DIN:   wr_bit = din_bit;
         default:  wr_bit = tag_q;
      endcase
   end

   assign wr_mask = pred ? tag_q : 1'b1;
   assign carry_o = carry_q;

   AST_CARRY_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_upd && !carry_clr && a_bit && b_bit) |=> carry_q); // R3

endmodule

// File: rtl/bsc_mem.sv
module bsc_mem #(
   parameter int ROWS = 32,
   parameter int COLS = 16,
   localparam int RW = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   rd_a_row,
   input  logic [RW-1:0]   rd_b_row,
   output logic [COLS-1:0] rd_a_data,
   output logic [COLS-1:0] rd_b_data,
   input  logic            seq_we,
   input  logic [RW-1:0]   seq_row,
   input  logic [COLS-1:0] seq_data,
   input  logic [COLS-1:0] seq_mask,
   input  logic            port_we,
   input  logic            port_rd,
   input  logic [RW-1:0]   port_row,
   input  logic [COLS-1:0] port_data,
   output logic [COLS-1:0] port_rdata
);

   logic [COLS-1:0] cells [ROWS];

   assign rd_a_data = cells[rd_a_row];
   assign rd_b_data = cells[rd_b_row];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++)
            cells[r] <= '0;
         port_rdata <= '0;
      end else begin
         if (seq_we) begin
            for (int c = 0; c < COLS; c++)
               if (seq_mask[c])
                  cells[seq_row][c] <= seq_data[c];
         end else if (port_we) begin
            cells[port_row] <= port_data;
         end
         if (port_rd)
            port_rdata <= cells[port_row];
      end
   end

   AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |-> !seq_we); // R7

endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
   import cim_pkg::*;
#(
   parameter int ROWS = 32,
   parameter int MAXW = 8,
   localparam int RW = $clog2(ROWS),
   localparam int WW = $clog2(MAXW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    code,
   input  logic [RW-1:0] a_base,
   input  logic [RW-1:0] b_base,
   input  logic [RW-1:0] d_base,
   input  logic [WW-1:0] width,
   output logic          start_ok,
   output logic          busy,
   output logic          done,
   output logic [RW-1:0] rd_a_row,
   output logic [RW-1:0] rd_b_row,
   output logic          wr_en,
   output logic [RW-1:0] wr_row,
   output wb_e           wb_sel,
   output logic          pred,
   output logic          tag_load,
   output logic          carry_clr,
   output logic          carry_upd
);

   localparam int CW = $clog2(2 * MAXW + 1);

   phase_e        phase_q;
   logic          mul_q;
   logic [WW-1:0] n_q;
   logic [RW-1:0] ab_q, bb_q, db_q;
   logic [CW-1:0] i_q, j_q;
   logic          done_q;

   logic [CW-1:0] nn;
   logic          last_j, last_i, last_zero;
   logic          legal;

   assign nn        = CW'(n_q);
   assign last_j    = (j_q == nn - CW'(1));
   assign last_i    = (i_q == nn - CW'(1));
   assign last_zero = (j_q == nn + nn - CW'(1));

   assign legal    = ((code == OP_ADD) || (code == OP_MUL)) &&
                     (width != '0) && (int'(width) <= MAXW);
   assign start_ok = start && (phase_q == PH_IDLE) && legal;
   assign busy     = (phase_q != PH_IDLE);
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         mul_q   <= 1'b0;
         n_q     <= '0;
         ab_q    <= '0;
         bb_q    <= '0;
         db_q    <= '0;
         i_q     <= '0;
         j_q     <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_ok) begin
                  mul_q   <= (code == OP_MUL);
                  n_q     <= width;
                  ab_q    <= a_base;
                  bb_q    <= b_base;
                  db_q    <= d_base;
                  i_q     <= '0;
                  j_q     <= '0;
                  phase_q <= (code == OP_MUL) ? PH_ZERO : PH_ADD;
               end
            end
            PH_ZERO: begin
               if (last_zero) begin
                  j_q     <= '0;
                  i_q     <= '0;
                  phase_q <= PH_TAG;
               end else begin
                  j_q <= j_q + CW'(1);
               end
            end
            PH_TAG: begin
               j_q     <= '0;
               phase_q <= (i_q == '0) ? PH_ADD : PH_CLR;
            end
            PH_CLR: begin
               phase_q <= PH_ADD;
            end
            PH_ADD: begin
               if (last_j) begin
                  j_q <= '0;
                  if (!mul_q) begin
                     phase_q <= PH_STC;
                  end else if (i_q == '0) begin
                     if (last_i) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        i_q     <= CW'(1);
                        phase_q <= PH_TAG;
                     end
                  end else begin
                     phase_q <= PH_STC;
                  end
               end else begin
                  j_q <= j_q + CW'(1);
               end
            end
            PH_STC: begin
               if (!mul_q || last_i) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  i_q     <= i_q + CW'(1);
                  phase_q <= PH_TAG;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_a_row  = ab_q;
      rd_b_row  = bb_q;
      wr_en     = 1'b0;
      wr_row    = db_q;
      wb_sel    = WB_DIN;
      pred      = 1'b0;
      tag_load  = 1'b0;
      carry_clr = start_ok;
      carry_upd = 1'b0;
      unique case (phase_q)
         PH_ZERO: begin
            wr_en  = 1'b1;
            wr_row = db_q + RW'(j_q);
            wb_sel = WB_DIN;
         end
         PH_TAG: begin
            rd_a_row = bb_q + RW'(i_q);
            rd_b_row = bb_q + RW'(i_q);
            tag_load = 1'b1;
         end
         PH_CLR: begin
            carry_clr = 1'b1;
         end
         PH_ADD: begin
            rd_a_row = ab_q + RW'(j_q);
            if (mul_q) begin
               rd_b_row = db_q + RW'(i_q) + RW'(j_q);
               wr_row   = db_q + RW'(i_q) + RW'(j_q);
            end else begin
               rd_b_row = bb_q + RW'(j_q);
               wr_row   = db_q + RW'(j_q);
            end
            wr_en     = 1'b1;
            wb_sel    = WB_SUM;
            pred      = mul_q;
            carry_upd = 1'b1;
         end
         PH_STC: begin
            wr_en  = 1'b1;
            wr_row = db_q + RW'(i_q) + RW'(n_q);
            wb_sel = WB_CARRY;
            pred   = mul_q;
         end
         default: ;
      endcase
   end

   logic [15:0] cyc_q;
   logic [15:0] n16, cyc_exp;

   assign n16     = 16'(n_q);
   assign cyc_exp = mul_q ? (n16 * n16 + 16'd5 * n16 - 16'd2) : (n16 + 16'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cyc_q <= '0;
      else if (start_ok)
         cyc_q <= '0;
      else if (busy)
         cyc_q <= cyc_q + 16'd1;
   end

   AST_CYCLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_q == cyc_exp)); // R4, R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(mul_q) && $stable(n_q) && $stable(db_q)); // R8

endmodule

// File: rtl/bitserial_cim.sv
module bitserial_cim
   import cim_pkg::*;
#(
   parameter int ROWS      = 32,
   parameter int COLS      = 16,
   parameter int MAXW      = 8,
   parameter bit SENSE_XOR = 1'b1,
   localparam int RW = $clog2(ROWS),
   localparam int WW = $clog2(MAXW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_start,
   input  logic [1:0]      op_code,
   input  logic [RW-1:0]   a_base,
   input  logic [RW-1:0]   b_base,
   input  logic [RW-1:0]   d_base,
   input  logic [WW-1:0]   op_width,
   output logic            busy,
   output logic            done,
   input  logic            acc_req,
   input  logic            acc_we,
   input  logic [RW-1:0]   acc_row,
   input  logic [COLS-1:0] acc_wdata,
   output logic            acc_gnt,
   output logic [COLS-1:0] acc_rdata
);

   localparam logic [COLS-1:0] FILL = '0;

   generate
      if (ROWS < 4 * MAXW) begin : g_bad_rows
         $error("ROWS must hold two operands and a double-width product");
      end
      if ((1 << RW) != ROWS) begin : g_bad_pow2
         $error("ROWS must be a power of two so row addresses wrap");
      end
      if (COLS < 1 || MAXW < 1) begin : g_bad_dims
         $error("COLS and MAXW must be at least 1");
      end
   endgenerate

   logic          start_ok;
   logic [RW-1:0] rd_a_row, rd_b_row, wr_row;
   logic          wr_en, pred, tag_load, carry_clr, carry_upd;
   wb_e           wb_sel;

   logic [COLS-1:0] rd_a_data, rd_b_data;
   logic [COLS-1:0] col_wdata, col_mask, carry_vec;

   logic port_we, port_rd;

   bsc_seq #(.ROWS(ROWS), .MAXW(MAXW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (op_start),
      .code      (op_code),
      .a_base    (a_base),
      .b_base    (b_base),
      .d_base    (d_base),
      .width     (op_width),
      .start_ok  (start_ok),
      .busy      (busy),
      .done      (done),
      .rd_a_row  (rd_a_row),
      .rd_b_row  (rd_b_row),
      .wr_en     (wr_en),
      .wr_row    (wr_row),
      .wb_sel    (wb_sel),
      .pred      (pred),
      .tag_load  (tag_load),
      .carry_clr (carry_clr),
      .carry_upd (carry_upd)
   );

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_col
         bsc_col #(.SENSE_XOR(SENSE_XOR)) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_bit     (rd_a_data[c]),
            .b_bit     (rd_b_data[c]),
            .din_bit   (FILL[c]),
            .wb_sel    (wb_sel),
            .pred      (pred),
            .tag_load  (tag_load),
            .carry_clr (carry_clr),
            .carry_upd (carry_upd),
            .wr_bit    (col_wdata[c]),
            .wr_mask   (col_mask[c]),
            .carry_o   (carry_vec[c])
         );
      end
   endgenerate

   assign acc_gnt = acc_req & ~busy;
   assign port_we = acc_gnt & acc_we;
   assign port_rd = acc_gnt & ~acc_we;

   bsc_mem #(.ROWS(ROWS), .COLS(COLS)) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a_row   (rd_a_row),
      .rd_b_row   (rd_b_row),
      .rd_a_data  (rd_a_data),
      .rd_b_data  (rd_b_data),
      .seq_we     (wr_en),
      .seq_row    (wr_row),
      .seq_data   (col_wdata),
      .seq_mask   (col_mask),
      .port_we    (port_we),
      .port_rd    (port_rd),
      .port_row   (acc_row),
      .port_data  (acc_wdata),
      .port_rdata (acc_rdata)
   );

   AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (carry_vec == '0)); // R9
   AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R10

endmodule

// File: tb/sim_bitserial_cim.sv
module sim_bitserial_cim;

   localparam int ROWS = 32;
   localparam int COLS = 16;
   localparam int MAXW = 8;
   localparam int AB = 0;
   localparam int BB = 8;
   localparam int DB = 16;

   localparam int NV = 13;
   localparam int V_OP  [NV] = '{1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 2, 2, 2};
   localparam int V_W   [NV] = '{2, 3, 5, 8, 8, 2, 3, 4, 5, 6, 7, 8, 8};
   localparam int V_PAT [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_start = 1'b0;
   logic [1:0]      op_code = 2'b00;
   logic [4:0]      a_base = 5'(AB);
   logic [4:0]      b_base = 5'(BB);
   logic [4:0]      d_base = 5'(DB);
   logic [3:0]      op_width = 4'd0;
   logic            busy, done;
   logic            acc_req = 1'b0;
   logic            acc_we = 1'b0;
   logic [4:0]      acc_row = '0;
   logic [COLS-1:0] acc_wdata = '0;
   logic            acc_gnt;
   logic [COLS-1:0] acc_rdata;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   logic [7:0]  av [COLS];
   logic [7:0]  bv [COLS];
   logic [15:0] res [COLS];

   always #2 clk = ~clk;

   bitserial_cim #(.ROWS(ROWS), .COLS(COLS), .MAXW(MAXW)) u0 (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
      .a_base(a_base), .b_base(b_base), .d_base(d_base), .op_width(op_width),
      .busy(busy), .done(done), .acc_req(acc_req), .acc_we(acc_we),
      .acc_row(acc_row), .acc_wdata(acc_wdata), .acc_gnt(acc_gnt),
      .acc_rdata(acc_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_row(input int row, input logic [COLS-1:0] data);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_row = 5'(row); acc_wdata = data;
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd_row(input int row, output logic [COLS-1:0] data);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b0; acc_row = 5'(row);
      @(negedge clk);
      acc_req = 1'b0;
      data = acc_rdata;
   endtask

   task automatic load_ops(input int n, input int pat);
      logic [COLS-1:0] ra, rb;
      int mask;
      mask = (1 << n) - 1;
      for (int c = 0; c < COLS; c++) begin
         av[c] = (pat == 1) ? 8'(mask) : 8'($urandom & mask);
         bv[c] = (pat == 1) ? 8'(mask) : 8'($urandom & mask);
      end
      for (int k = 0; k < n; k++) begin
         for (int c = 0; c < COLS; c++) begin
            ra[c] = av[c][k];
            rb[c] = bv[c][k];
         end
         wr_row(AB + k, ra);
         wr_row(BB + k, rb);
      end
   endtask

   task automatic run_op(input int op, input int n, output int cycles, output bit dn);
      @(negedge clk);
      op_start = 1'b1; op_code = 2'(op); op_width = 4'(n);
      @(negedge clk);
      op_start = 1'b0;
      cycles = 0;
      while (busy && cycles < 5000) begin
         cycles++;
         @(negedge clk);
      end
      dn = done;
   endtask

   task automatic get_result(input int nrows);
      logic [COLS-1:0] r;
      for (int c = 0; c < COLS; c++) res[c] = '0;
      for (int k = 0; k < nrows; k++) begin
         rd_row(DB + k, r);
         for (int c = 0; c < COLS; c++) res[c][k] = r[c];
      end
   endtask

   task automatic cmp_result(input int op, input string req);
      int bad, act, exp;
      bad = -1; act = 0; exp = 0;
      for (int c = 0; c < COLS; c++) begin
         int e;
         e = (op == 1) ? (int'(av[c]) + int'(bv[c])) : (int'(av[c]) * int'(bv[c]));
         if (bad < 0 && int'(res[c]) != e) begin
            bad = c; act = int'(res[c]); exp = e;
         end
      end
      chk(bad < 0, req, act, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
         $finish;
      end
   end

   initial begin
      int cyc;
      bit dn;
      logic [COLS-1:0] r;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      rd_row(3, r);
      chk(r == '0, "R1 row 3 after reset", int'(r), 0);
      rd_row(31, r);
      chk(r == '0, "R1 row 31 after reset", int'(r), 0);

      // R2: row port grant, write and read back
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_row = 5'd5; acc_wdata = 16'h3C5A;
      #1 chk(acc_gnt == 1'b1, "R2 grant when idle", int'(acc_gnt), 1);
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0;
      rd_row(5, r);
      chk(r == 16'h3C5A, "R2 read back", int'(r), 'h3C5A);

      // table of vectors: R3/R4 for add, R5/R6 for multiply
      for (int v = 0; v < NV; v++) begin
         int n, op;
         n = V_W[v]; op = V_OP[v];
         load_ops(n, V_PAT[v]);
         run_op(op, n, cyc, dn);
         if (op == 1) begin
            chk(cyc == n + 1, "R4 add busy cycles", cyc, n + 1);
            chk(dn == 1'b1, "R4 add done pulse", int'(dn), 1);
            @(negedge clk);
            chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
            get_result(n + 1);
            cmp_result(op, "R3 add result");
         end else begin
            chk(cyc == n * n + 5 * n - 2, "R6 mul busy cycles", cyc, n * n + 5 * n - 2);
            chk(dn == 1'b1, "R6 mul done pulse", int'(dn), 1);
            get_result(2 * n);
            cmp_result(op, "R5 mul result");
         end
      end

      // R7 and R8: stalled port write and ignored start during a multiply
      load_ops(8, 0);
      @(negedge clk);
      op_start = 1'b1; op_code = 2'b10; op_width = 4'd8;
      @(negedge clk);
      op_start = 1'b0;
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         if (cyc == 4) begin
            acc_req = 1'b1; acc_we = 1'b1; acc_row = 5'd0; acc_wdata = ~16'h0;
            op_start = 1'b1; op_code = 2'b01; op_width = 4'd2;
            #1 chk(acc_gnt == 1'b0, "R7 no grant while busy", int'(acc_gnt), 0);
         end
         @(negedge clk);
         acc_req = 1'b0; acc_we = 1'b0; op_start = 1'b0;
      end
      chk(cyc == 102, "R8 restart ignored, mul length kept", cyc, 102);
      @(negedge clk);
      chk(busy == 1'b0, "R8 no queued restart", int'(busy), 0);
      get_result(16);
      cmp_result(2, "R5 mul result with stalled access");
      rd_row(AB, r);
      begin
         logic [COLS-1:0] e;
         for (int c = 0; c < COLS; c++) e[c] = av[c][0];
         chk(r == e, "R7 stalled write had no effect", int'(r), int'(e));
      end
      rd_row(BB + 7, r);
      begin
         logic [COLS-1:0] e;
         for (int c = 0; c < COLS; c++) e[c] = bv[c][7];
         chk(r == e, "R10 multiplier row kept", int'(r), int'(e));
      end

      // R8: illegal starts
      @(negedge clk);
      op_start = 1'b1; op_code = 2'b01; op_width = 4'd0;
      @(negedge clk);
      op_start = 1'b0;
      chk(busy == 1'b0, "R8 width 0 ignored", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 width 0 no done", int'(done), 0);
      op_start = 1'b1; op_code = 2'b10; op_width = 4'd9;
      @(negedge clk);
      op_start = 1'b0;
      chk(busy == 1'b0, "R8 width above MAXW ignored", int'(busy), 0);
      op_start = 1'b1; op_code = 2'b00; op_width = 4'd4;
      @(negedge clk);
      op_start = 1'b0;
      chk(busy == 1'b0, "R8 code 00 ignored", int'(busy), 0);
      op_start = 1'b1; op_code = 2'b11; op_width = 4'd4;
      @(negedge clk);
      op_start = 1'b0;
      chk(busy == 1'b0, "R8 code 11 ignored", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R8 no done after illegal", int'(done), 0);

      // R9: carry left set by one add must not reach the next
      load_ops(4, 1);
      run_op(1, 4, cyc, dn);
      load_ops(4, 2);
      for (int c = 0; c < COLS; c++) begin av[c] = 8'd0; bv[c] = 8'd0; end
      for (int k = 0; k < 4; k++) begin
         wr_row(AB + k, '0);
         wr_row(BB + k, '0);
      end
      run_op(1, 4, cyc, dn);
      get_result(5);
      cmp_result(1, "R9 zero add after carry-out add");

      // R10: a row outside the result window is untouched
      wr_row(31, 16'hA5C3);
      load_ops(4, 0);
      run_op(1, 4, cyc, dn);
      rd_row(31, r);
      chk(r == 16'hA5C3, "R10 row outside window", int'(r), 'hA5C3);
      get_result(5);
      cmp_result(1, "R3 add result beside guarded row");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule